// File: doc/BRIEF.md
# Multiplexed Bank-Address Demultiplexer and Bus Cycle Classifier

This block is placed beside a 16-bit-address processor that sends the top byte of its 24-bit address over the shared 8-bit data bus while the phase-2 clock is low. During the high phase, the same bus carries data. The block samples the bus on every clock of the low phase. At the rising edge of phase-2, it freezes the last sample as the bank byte and pairs it with the 16-bit low address. The result is a 24-bit address that stays constant until the next rising edge.

At the same rising edge, the block decodes the two status lines, valid-data and valid-program. From them it forms a two-bit cycle kind and a flag that is set when the bank byte came from the program bank. It also flags internal cycles as carrying no valid address. For read cycles, it drives memory read data back towards the processor, but only while phase-2 has been high for at least one clock. This keeps the return path off the bus during the time the bank byte is on it.

All logic runs on one fast system clock. The phase-2 clock is an ordinary input sampled on that clock, so a phase-2 edge is seen on the first system clock after it happens.

Top module: `busdemux816`

## Requirements
- R1: The bank byte in `addr_full[23:16]` is the value of `bus_d` on the last system clock at which `phi2` was sampled low before the rising phase-2 edge. Earlier low-phase values do not affect it.
- R2: `addr_full[15:0]` is the value of `addr_lo` sampled on the same clock that first sees `phi2` high.
- R3: All outputs other than `data_oe` and `data_out` appear one clock after the rising edge is sampled. They then stay unchanged until the next rising edge, including through the following low phase.
- R4: The cycle kind `cyc_type` is encoded as follows: 2'b11 when `vda`=1 and `vpa`=1 (opcode fetch), 2'b10 when `vda`=0 and `vpa`=1 (operand fetch), 2'b01 when `vda`=1 and `vpa`=0 (data access), and 2'b00 when both are 0 (internal).
- R5: `prog_bank` is 1 for opcode and operand fetches and 0 for data and internal cycles.
- R6: `addr_valid` is 0 for an internal cycle and 1 for every other cycle kind.
- R7: `data_oe` is 1 only when all of these hold: `phi2` is high now, `phi2` was high on the previous clock, the current cycle is not internal, and it is a read (`rwb`=1 at the edge). While `data_oe` is 1, `data_out` equals `mem_rdata`. Otherwise `data_out` is 0. `data_oe` drops on the same clock that `phi2` is seen low.
- R8: A write cycle (`rwb`=0) never raises `data_oe`.
- R9: While `rst_n` is low, `addr_full` is 0, `cyc_type` is 2'b00, and `prog_bank`, `addr_valid` and `data_oe` are 0.
- R10: After reset, rising edges are ignored until one falling phase-2 edge has been seen. Until then, the outputs keep their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than phase-2 |
| rst_n | input | 1 | Synchronous active-low reset |
| phi2 | input | 1 | Processor phase-2 clock, sampled |
| addr_lo | input | 16 | Processor low address lines |
| bus_d | input | 8 | Shared data bus as observed (bank byte in low phase) |
| vda | input | 1 | Valid-data status line |
| vpa | input | 1 | Valid-program status line |
| rwb | input | 1 | 1 = read, 0 = write |
| mem_rdata | input | 8 | Read data returned by memory |
| addr_full | output | 24 | Rebuilt 24-bit address |
| addr_valid | output | 1 | Address belongs to a non-internal cycle |
| cyc_type | output | 2 | Cycle kind (R4 encoding) |
| prog_bank | output | 1 | Bank byte came from the program bank |
| data_out | output | 8 | Read data towards the processor, 0 when not driving |
| data_oe | output | 1 | Enable for the external bus driver |

## Verification
The bench changes `bus_d` partway through each low phase. A design that latched the first low-phase sample, or kept sampling into the high phase, would therefore show the wrong bank byte. It compares the held address on every clock of the following low phase, which exposes a design that lets the bank byte follow the bus. The bench also releases reset with phase-2 already high, where a design that skipped the arming rule would classify a half cycle. Finally, it runs write cycles and internal cycles with memory data present, so a return-path enable that ignores the direction or the cycle kind would drive the bus.

// File: rtl/busdemux816_pkg.sv
// Package: shared types and the status-line decode for the bus demultiplexer.
// Assumes status lines are sampled at the rising phase-2 edge.
package busdemux816_pkg;

    typedef enum logic [1:0] {
        CYC_INTERNAL = 2'b00,
        CYC_DATA     = 2'b01,
        CYC_OPERAND  = 2'b10,
        CYC_OPCODE   = 2'b11
    } cyc_kind_t;

    // Map the valid-data / valid-program pair onto a cycle kind.
    function automatic cyc_kind_t classify(input logic v_data, input logic v_prog);
        cyc_kind_t k;
        case ({v_prog, v_data})
            2'b11:   k = CYC_OPCODE;
            2'b10:   k = CYC_OPERAND;
            2'b01:   k = CYC_DATA;
            default: k = CYC_INTERNAL;
        endcase
        return k;
    endfunction

    // Bank byte is supplied by the program bank for both fetch kinds.
    function automatic logic from_program_bank(input cyc_kind_t k);
        return (k == CYC_OPCODE) || (k == CYC_OPERAND);
    endfunction

endpackage

// File: rtl/bd_phase_track.sv
// Phase tracker: samples phase-2 on the system clock, reports rising and
// falling edges, and arms the block once a full high phase has ended.
// Assumes phi2 is already synchronous to clk (or synchronised upstream).
module bd_phase_track (
    input  logic clk,
    input  logic rst_n,
    input  logic phi2,
    output logic phi2_d,
    output logic rise,
    output logic armed
);
    logic fall;

    // Keep the previous sample of phase-2.
    always_ff @(posedge clk) begin
        if (!rst_n) phi2_d <= 1'b0;
        else        phi2_d <= phi2;
    end

    assign rise = phi2 & ~phi2_d;
    assign fall = ~phi2 & phi2_d;

    // Arm on the first falling edge after reset, stay armed afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)    armed <= 1'b0;
        else if (fall) armed <= 1'b1;
    end
endmodule

// File: rtl/bd_bank_capture.sv
// Bank capture: behaves like a transparent latch in the system-clock domain,
// following the shared bus while phase-2 is low and holding while high.
// Assumes the bus is stable on the last low-phase clock.
module bd_bank_capture #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic [BANK_W-1:0] bus_in,
    output logic [BANK_W-1:0] bank
);
    // Follow the bus during the low phase only.
    always_ff @(posedge clk) begin
        if (!rst_n)     bank <= '0;
        else if (!phi2) bank <= bus_in;
    end
endmodule

// File: rtl/bd_cycle_register.sv
// Cycle register: at an armed rising edge, snapshots the full address,
// the cycle kind and the direction, and holds them until the next edge.
// Assumes capture is a single-clock pulse.
module bd_cycle_register
    import busdemux816_pkg::*;
#(
    parameter int LO_W   = 16,
    parameter int BANK_W = 8,
    localparam int ADDR_W = LO_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [LO_W-1:0]   addr_lo,
    input  logic              vda,
    input  logic              vpa,
    input  logic              rwb,
    output logic [ADDR_W-1:0] addr_q,
    output cyc_kind_t         kind_q,
    output logic              rd_q
);
    // Snapshot address and status once per phase-2 period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            kind_q <= CYC_INTERNAL;
            rd_q   <= 1'b0;
        end else if (capture) begin
            addr_q <= {bank_in, addr_lo};
            kind_q <= classify(vda, vpa);
            rd_q   <= rwb;
        end
    end
endmodule

// File: rtl/bd_data_drive.sv
// Read-data return path: enables the bus driver only after phase-2 has been
// high for at least one clock, and only for valid read cycles.
// Assumes the external pad applies high impedance when data_oe is low.
module bd_data_drive #(
    parameter int DATA_W = 8
) (
    input  logic              phi2,
    input  logic              phi2_d,
    input  logic              cyc_valid,
    input  logic              rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              data_oe,
    output logic [DATA_W-1:0] data_out
);
    // Combinational so the enable drops on the first low sample.
    always_comb begin
        data_oe  = phi2 & phi2_d & cyc_valid & rd;
        data_out = data_oe ? mem_rdata : '0;
    end
endmodule

// File: rtl/busdemux816.sv
// Top: rebuilds the 24-bit address from the low address lines and the bank
// byte carried on the data bus in the low phase, classifies each bus cycle
// and steers memory read data back during the high phase.
// Assumes a system clock several times faster than phase-2.
module busdemux816
    import busdemux816_pkg::*;
#(
    parameter int LO_W   = 16,
    parameter int BANK_W = 8,
    localparam int ADDR_W = LO_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic [LO_W-1:0]   addr_lo,
    input  logic [BANK_W-1:0] bus_d,
    input  logic              vda,
    input  logic              vpa,
    input  logic              rwb,
    input  logic [BANK_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] addr_full,
    output logic              addr_valid,
    output logic [1:0]        cyc_type,
    output logic              prog_bank,
    output logic [BANK_W-1:0] data_out,
    output logic              data_oe
);
    logic              phi2_d;
    logic              rise_w;
    logic              armed_w;
    logic [BANK_W-1:0] bank_w;
    cyc_kind_t         kind_w;
    logic              rd_w;

    bd_phase_track u_phase (
        .clk(clk), .rst_n(rst_n), .phi2(phi2),
        .phi2_d(phi2_d), .rise(rise_w), .armed(armed_w)
    );

    bd_bank_capture #(.BANK_W(BANK_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .phi2(phi2),
        .bus_in(bus_d), .bank(bank_w)
    );

    bd_cycle_register #(.LO_W(LO_W), .BANK_W(BANK_W)) u_cyc (
        .clk(clk), .rst_n(rst_n), .capture(rise_w & armed_w),
        .bank_in(bank_w), .addr_lo(addr_lo), .vda(vda), .vpa(vpa), .rwb(rwb),
        .addr_q(addr_full), .kind_q(kind_w), .rd_q(rd_w)
    );

    // Derive the per-cycle flags from the held cycle kind.
    always_comb begin
        cyc_type   = kind_w;
        addr_valid = (kind_w != CYC_INTERNAL);
        prog_bank  = from_program_bank(kind_w);
    end

    bd_data_drive #(.DATA_W(BANK_W)) u_drive (
        .phi2(phi2), .phi2_d(phi2_d), .cyc_valid(addr_valid), .rd(rd_w),
        .mem_rdata(mem_rdata), .data_oe(data_oe), .data_out(data_out)
    );
endmodule

// File: rtl/busdemux816_chk.sv
// Checker: temporal properties of the demultiplexer, bound to the top.
module busdemux816_chk #(
    parameter int LO_W   = 16,
    parameter int BANK_W = 8,
    localparam int ADDR_W = LO_W + BANK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phi2,
    input logic [LO_W-1:0]   addr_lo,
    input logic [BANK_W-1:0] bus_d,
    input logic              vda,
    input logic              vpa,
    input logic              rwb,
    input logic [ADDR_W-1:0] addr_full,
    input logic              addr_valid,
    input logic [1:0]        cyc_type,
    input logic              prog_bank,
    input logic              data_oe,
    input logic              rise,
    input logic              armed
);
    a_r1_bank_last_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && armed) |=> addr_full[ADDR_W-1:LO_W] == $past(bus_d, 2));

    a_r2_low_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && armed) |=> addr_full[LO_W-1:0] == $past(addr_lo));

    a_r3_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> ($stable(addr_full) && $stable(cyc_type)));

    a_r4_opcode_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && armed && vda && vpa) |=> cyc_type == 2'b11);

    a_r5_data_not_program: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && armed && vda && !vpa) |=> (cyc_type == 2'b01 && !prog_bank));

    a_r5_operand_program: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && armed && !vda && vpa) |=> (cyc_type == 2'b10 && prog_bank));

    a_r6_internal_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && armed && !vda && !vpa) |=> !addr_valid);

    a_r7_oe_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (phi2 && addr_valid));

    a_r8_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && armed && !rwb) |=> !data_oe);

    a_r10_unarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (cyc_type == 2'b00 && addr_full == '0));
endmodule

bind busdemux816 busdemux816_chk #(.LO_W(LO_W), .BANK_W(BANK_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .addr_lo(addr_lo), .bus_d(bus_d),
    .vda(vda), .vpa(vpa), .rwb(rwb), .addr_full(addr_full),
    .addr_valid(addr_valid), .cyc_type(cyc_type), .prog_bank(prog_bank),
    .data_oe(data_oe), .rise(rise_w), .armed(armed_w)
);

// File: tb/busdemux816_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module busdemux816_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2 = 1'b1;
    logic [15:0] addr_lo = '0;
    logic [7:0]  bus_d = '0;
    logic        vda = 1'b0, vpa = 1'b0, rwb = 1'b1;
    logic [7:0]  mem_rdata = '0;
    logic [23:0] addr_full;
    logic        addr_valid, prog_bank, data_oe;
    logic [1:0]  cyc_type;
    logic [7:0]  data_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    busdemux816 dut_i (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .addr_lo(addr_lo), .bus_d(bus_d),
        .vda(vda), .vpa(vpa), .rwb(rwb), .mem_rdata(mem_rdata),
        .addr_full(addr_full), .addr_valid(addr_valid), .cyc_type(cyc_type),
        .prog_bank(prog_bank), .data_out(data_out), .data_oe(data_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model state.
    int  m_addr = 0, m_type = 0, m_last_low = 0;
    bit  m_rd = 0, m_prev = 0, m_armed = 0;

    // Model update on each clock, inputs are stable here.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_type = 0; m_last_low = 0;
            m_rd = 0; m_prev = 0; m_armed = 0;
        end else begin
            if (phi2 && !m_prev && m_armed) begin
                m_addr = (m_last_low << 16) | int'(addr_lo);
                if (vda && vpa)       m_type = 3;
                else if (vpa)         m_type = 2;
                else if (vda)         m_type = 1;
                else                  m_type = 0;
                m_rd = rwb;
            end
            if (m_prev && !phi2) m_armed = 1;
            if (!phi2) m_last_low = int'(bus_d);
            m_prev = phi2;
        end
    end

    // Compare every output mid-period.
    always @(negedge clk) begin
        bit eoe;
        if (!done) begin
            eoe = phi2 && m_prev && (m_type != 0) && m_rd;
            chk("R1 bank", int'(addr_full[23:16]), (m_addr >> 16) & 255);
            chk("R2 low", int'(addr_full[15:0]), m_addr & 16'hFFFF);
            chk("R4 kind", int'(cyc_type), m_type);
            chk("R5 prog_bank", int'(prog_bank), (m_type >= 2) ? 1 : 0);
            chk("R6 valid", int'(addr_valid), (m_type != 0) ? 1 : 0);
            chk("R7 oe", int'(data_oe), int'(eoe));
            chk("R7 data_out", int'(data_out), eoe ? int'(mem_rdata) : 0);
        end
    end

    // One phase-2 period: 3 clocks low (bus changes mid-phase), 3 clocks high.
    task automatic bus_cycle(input logic [7:0] bank, input logic [15:0] lo,
                             input logic d, input logic p, input logic r,
                             input logic [7:0] rdata);
        @(posedge clk); #2;
        phi2 = 1'b0; bus_d = ~bank; addr_lo = lo; vda = d; vpa = p; rwb = r;
        @(posedge clk); #2; bus_d = bank ^ 8'h5A;
        @(posedge clk); #2; bus_d = bank;
        @(posedge clk); #2;
        phi2 = 1'b1; bus_d = r ? rdata : 8'hC3; mem_rdata = rdata;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R9: reset state
        chk("R9 addr", int'(addr_full), 0);
        chk("R9 kind", int'(cyc_type), 0);
        chk("R9 oe", int'(data_oe), 0);
        rst_n = 1'b1;  // released with phi2 high
        @(posedge clk); #2;
        // R10: a half period right after reset is ignored
        chk("R10 unarmed", int'(addr_valid), 0);
        bus_cycle(8'h12, 16'h3456, 1, 1, 1, 8'hA9);  // first full period classifies
        @(negedge clk);
        chk("R4 opcode", int'(cyc_type), 3);
        chk("R1 bank last", int'(addr_full), 24'h123456);
        chk("R7 read drive", int'(data_out), 8'hA9);
        bus_cycle(8'h7E, 16'hFFFF, 0, 1, 1, 8'h01);
        @(negedge clk);
        chk("R5 operand", int'(prog_bank), 1);
        bus_cycle(8'h00, 16'h0000, 1, 0, 0, 8'hEE);
        @(negedge clk);
        chk("R8 write no oe", int'(data_oe), 0);
        chk("R5 data", int'(prog_bank), 0);
        bus_cycle(8'hFF, 16'h8001, 0, 0, 1, 8'h77);
        @(negedge clk);
        chk("R6 internal", int'(addr_valid), 0);
        chk("R7 internal no oe", int'(data_oe), 0);
        bus_cycle(8'hA5, 16'h1234, 1, 0, 1, 8'h3C);
        // R3: into the next low phase, address still held
        @(posedge clk); #2; phi2 = 1'b0; bus_d = 8'h99; addr_lo = 16'h0BAD;
        @(negedge clk);
        chk("R3 hold", int'(addr_full), 24'hA51234);
        chk("R7 oe drops", int'(data_oe), 0);
        for (int i = 0; i < 40; i++)
            bus_cycle(8'(i * 37), 16'(i * 1021), i[0], i[1], i[2], 8'(i + 3));
        // R9: reset mid-run
        @(posedge clk); #2; rst_n = 1'b0;
        @(posedge clk); #2;
        chk("R9 mid reset", int'(addr_full), 0);
        chk("R9 mid reset prog", int'(prog_bank), 0);
        rst_n = 1'b1;
        bus_cycle(8'h33, 16'h4444, 1, 1, 1, 8'h55);
        bus_cycle(8'h66, 16'h7777, 1, 1, 1, 8'h88);
        @(negedge clk);
        chk("R10 rearmed", int'(addr_full), 24'h667777);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule